// File: doc/BRIEF.md
# Nonvolatile Byte Store Access Controller

This block connects a CPU register bus to a 1024-byte nonvolatile byte store that it models internally. Software sees four byte registers in one aligned group: the low and high halves of a 10-bit byte address, a data byte and a control byte. A read copies the addressed byte into the data register. A write copies the data register into the store. It takes a programming time set by a parameter.

Writes are guarded by a timed two-step unlock. Software first arms a master-write-enable bit. That bit clears itself four cycles later. A write starts only if software sets the write-enable bit while the arm is still live. Write-enable then stays high until programming ends. The address and data registers are frozen while the write runs. A ready interrupt request is a level, not a pulse: it is held high while the store is idle, but only when software has enabled it and the global interrupt-enable input is high.

Top module: `nvm_access_ctrl`

## Requirements
- R1: The byte address is 10 bits and selects bytes 0 to 1023 linearly. The register at offset 0 holds address bits 7:0. The register at offset 1 holds bits 9:8 in its bits 1:0, and its bits 7:2 always read as zero. The address has no defined reset value.
- R2: The control register sits at offset 3. Its bit 3 is the ready-interrupt enable, bit 2 is master-write-enable, bit 1 is write-enable and bit 0 is read-enable. Bits 7:4 ignore writes and always read as zero.
- R3: If write-enable is written as one while master-write-enable is set, the data register byte (offset 2) is stored at the addressed location.
- R4: Master-write-enable reads one after software writes it as one. Hardware clears it four clock cycles later, so a write-enable set on any of the next four clock edges is accepted.
- R5: If master-write-enable is zero, including after the four-cycle window has lapsed, writing write-enable as one has no effect: the bit reads zero and the store is unchanged.
- R6: Once a write starts, write-enable reads one for exactly WR_CYCLES cycles and is then cleared by hardware. The new byte is readable after that point.
- R7: Writing read-enable as one makes the bit read one for one cycle. On the next clock edge the data register loads the addressed byte and read-enable reads zero.
- R8: A read-enable request made while a write is busy is ignored, and the data register keeps its value.
- R9: While a write is busy, bus writes to the address and data registers are ignored.
- R10: The interrupt output is high exactly when the ready-interrupt enable and the global interrupt-enable input are both one and write-enable is zero.
- R11: After reset the data and control registers read zero and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address on the register bus; the block answers in a four-byte group at BASE_ADDR |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Ready interrupt request (level) |

## Verification
If the unlock counter runs too long or too short, the control byte read back on the cycles after arming shows master-write-enable clearing on the wrong edge. A write-enable landing on the fifth edge then starts a write, or one on the fourth edge is dropped. Both show at the bus within one cycle. A busy counter that is off by one changes the number of cycles that write-enable reads high, and it moves the point where the interrupt rises. A missing busy guard on the address, data or read-enable path shows up as a changed data byte, a changed address or a wrong stored byte as soon as the write finishes.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    localparam int MEM_BYTES  = 1024;
    localparam int NVM_AW     = $clog2(MEM_BYTES);
    localparam int HI_W       = NVM_AW - 8;
    localparam int UNLOCK_WIN = 4;

    typedef enum logic [1:0] {
        REG_ADDR_LO = 2'd0,
        REG_ADDR_HI = 2'd1,
        REG_DATA    = 2'd2,
        REG_CTRL    = 2'd3
    } reg_sel_e;

    localparam int CB_RIE = 3;
    localparam int CB_MWE = 2;
    localparam int CB_WE  = 1;
    localparam int CB_RE  = 0;

    typedef struct packed {
        logic rie;
        logic mwe;
        logic we;
        logic re;
    } ctrl_bits_t;

    function automatic logic [7:0] pack_ctrl(ctrl_bits_t c);
        return {4'b0000, c};
    endfunction

endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic disarm,
    output logic armed
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || disarm) cnt_q <= '0;
        else if (arm) cnt_q <= CW'(WIN);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign armed = (cnt_q != '0);

    // R4
    arm_sets_chk: assert property (@(posedge clk) disable iff (rst)
        arm && !disarm |=> armed);

endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
    parameter int BYTES     = 1024,
    parameter int AW        = 10,
    parameter int WR_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy,
    output logic          commit
);
    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [7:0]    mem [BYTES];
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] lat_addr_q;
    logic [7:0]    lat_data_q;

    assign busy   = (cnt_q != '0);
    assign commit = (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else if (start && !busy) cnt_q <= CW'(WR_CYCLES);
        else if (busy) cnt_q <= cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (start && !busy) begin
            lat_addr_q <= wr_addr;
            lat_data_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (commit) mem[lat_addr_q] <= lat_data_q;
    end

    assign rd_data = mem[rd_addr];

    // R6
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R6
    commit_idle_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> !busy);

endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl
    import nvm_pkg::*;
#(
    parameter int         WR_CYCLES = 8,
    parameter logic [7:0] BASE_ADDR = 8'h1C
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       gie,
    output logic       irq
);
    logic              hit;
    reg_sel_e          sel;
    logic              wr_lo, wr_hi, wr_dat, wr_ctl;
    logic [NVM_AW-1:0] addr_q;
    logic [7:0]        data_q;
    logic              rie_q, re_q;
    logic              armed, busy, commit, start, rd_req, arm, disarm;
    logic [7:0]        rd_byte;
    ctrl_bits_t        ctrl_view;

    assign hit    = (bus_addr[7:2] == BASE_ADDR[7:2]);
    assign sel    = reg_sel_e'(bus_addr[1:0]);
    assign wr_lo  = bus_wr && hit && (sel == REG_ADDR_LO);
    assign wr_hi  = bus_wr && hit && (sel == REG_ADDR_HI);
    assign wr_dat = bus_wr && hit && (sel == REG_DATA);
    assign wr_ctl = bus_wr && hit && (sel == REG_CTRL);

    assign start  = wr_ctl && bus_wdata[CB_WE] && armed && !busy;
    assign rd_req = wr_ctl && bus_wdata[CB_RE] && !busy && !start;
    assign arm    = wr_ctl && bus_wdata[CB_MWE] && !start;
    assign disarm = start || (wr_ctl && !bus_wdata[CB_MWE]);

    nvm_unlock #(.WIN(UNLOCK_WIN)) u_unlock (
        .clk    (clk),
        .rst    (rst),
        .arm    (arm),
        .disarm (disarm),
        .armed  (armed)
    );

    nvm_array #(.BYTES(MEM_BYTES), .AW(NVM_AW), .WR_CYCLES(WR_CYCLES)) u_array (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .wr_addr (addr_q),
        .wr_data (data_q),
        .rd_addr (addr_q),
        .rd_data (rd_byte),
        .busy    (busy),
        .commit  (commit)
    );

    // address: deliberately without reset
    always_ff @(posedge clk) begin
        if (wr_lo && !busy) addr_q[7:0] <= bus_wdata;
        if (wr_hi && !busy) addr_q[NVM_AW-1:8] <= bus_wdata[HI_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            rie_q  <= 1'b0;
            re_q   <= 1'b0;
        end else begin
            re_q <= rd_req;
            if (wr_ctl) rie_q <= bus_wdata[CB_RIE];
            if (re_q) data_q <= rd_byte;
            else if (wr_dat && !busy) data_q <= bus_wdata;
        end
    end

    assign ctrl_view = '{rie: rie_q, mwe: armed, we: busy, re: re_q};

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            unique case (sel)
                REG_ADDR_LO: bus_rdata = addr_q[7:0];
                REG_ADDR_HI: bus_rdata = {{(8 - HI_W){1'b0}}, addr_q[NVM_AW-1:8]};
                REG_DATA:    bus_rdata = data_q;
                REG_CTRL:    bus_rdata = pack_ctrl(ctrl_view);
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign irq = rie_q && gie && !busy;

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !irq);

    // R7
    re_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
        re_q && !rd_req |=> !re_q);

    // R9
    data_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !re_q |=> $stable(data_q));

    // R5
    start_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ctl && bus_wdata[CB_WE] && !armed |=> !busy || $past(busy));

endmodule

// File: tb/nvm_access_ctrl_test.sv
module nvm_access_ctrl_test;
    localparam int         WR   = 8;
    localparam logic [7:0] BASE = 8'h1C;

    typedef struct packed {
        logic       is_wr;
        logic [1:0] off;
        logic [7:0] val;
    } vec_t;

    // offsets: 0 addr lo, 1 addr hi, 2 data, 3 control
    localparam vec_t TBL [14] = '{
        '{1'b1, 2'd0, 8'h5A}, '{1'b0, 2'd0, 8'h5A},   // R1
        '{1'b1, 2'd1, 8'hFE}, '{1'b0, 2'd1, 8'h02},   // R1
        '{1'b1, 2'd2, 8'hC3}, '{1'b0, 2'd2, 8'hC3},
        '{1'b1, 2'd3, 8'hF0}, '{1'b0, 2'd3, 8'h00},   // R2
        '{1'b1, 2'd3, 8'h08}, '{1'b0, 2'd3, 8'h08},   // R2
        '{1'b1, 2'd3, 8'h0A}, '{1'b0, 2'd3, 8'h08},   // R5
        '{1'b1, 2'd3, 8'h00}, '{1'b0, 2'd3, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = BASE;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       gie = 1'b1;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    nvm_access_ctrl #(.WR_CYCLES(WR), .BASE_ADDR(BASE)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // call just after a rising edge or just after a read
    task automatic wr(input logic [1:0] off, input logic [7:0] d);
        bus_addr = BASE + 8'(off); bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [1:0] off, output logic [7:0] v);
        @(negedge clk);
        bus_addr = BASE + 8'(off);
        #1 v = bus_rdata;
    endtask

    task automatic mem_read(input logic [9:0] a, output logic [7:0] v);
        wr(2'd0, a[7:0]);
        wr(2'd1, {6'b0, a[9:8]});
        wr(2'd3, 8'h01);
        idle(1);
        rd(2'd2, v);
    endtask

    initial begin
        logic [7:0] v;
        int hi;
        idle(3);
        rst = 1'b0;
        idle(1);
        // R11 reset state
        rd(2'd2, v); chk("R11 data", v, 8'h00);
        rd(2'd3, v); chk("R11 ctrl", v, 8'h00);
        checks++; if (irq !== 1'b0) begin errors++; $display("FAIL R11 irq: got %0b expected 0", irq); end

        for (int i = 0; i < 14; i++) begin
            if (TBL[i].is_wr) wr(TBL[i].off, TBL[i].val);
            else begin rd(TBL[i].off, v); chk($sformatf("R1/R2/R5 vector %0d", i), v, TBL[i].val); end
        end

        // R4: arm then watch master-write-enable across edges
        wr(2'd3, 8'h04);
        for (int k = 0; k < 6; k++) begin
            rd(2'd3, v);
            chk($sformatf("R4 mwe k=%0d", k), {7'b0, v[2]}, (k < 4) ? 8'h01 : 8'h00);
        end

        // R3: write-enable on the fourth edge after arming
        wr(2'd0, 8'hFF); wr(2'd1, 8'h03); wr(2'd2, 8'h3C);
        wr(2'd3, 8'h0C);
        idle(3);
        wr(2'd3, 8'h0A);
        // R10: interrupt low while busy
        checks++; if (irq !== 1'b0) begin errors++; $display("FAIL R10 irq busy: got %0b expected 0", irq); end
        // R6: write-enable high for WR cycles
        hi = 0;
        for (int k = 0; k < WR + 3; k++) begin rd(2'd3, v); if (v[1]) hi++; end
        chk("R6 busy length", 8'(hi), 8'(WR));
        checks++; if (irq !== 1'b1) begin errors++; $display("FAIL R10 irq idle: got %0b expected 1", irq); end
        gie = 1'b0; #1;
        checks++; if (irq !== 1'b0) begin errors++; $display("FAIL R10 irq gie off: got %0b expected 0", irq); end
        gie = 1'b1;

        // R7: read-enable behaviour
        wr(2'd3, 8'h01);
        rd(2'd3, v); chk("R7 re visible", v, 8'h01);
        rd(2'd2, v); chk("R3/R7 stored byte", v, 8'h3C);
        rd(2'd3, v); chk("R7 re cleared", v, 8'h00);

        // R5: write-enable on the fifth edge is rejected
        wr(2'd2, 8'h99);
        wr(2'd3, 8'h04);
        idle(4);
        wr(2'd3, 8'h02);
        rd(2'd3, v); chk("R5 we stays 0", v, 8'h00);
        mem_read(10'h3FF, v); chk("R5 store unchanged", v, 8'h3C);

        // R8 / R9: bus activity during a busy write
        wr(2'd0, 8'h01); wr(2'd1, 8'h00); wr(2'd2, 8'h81);
        wr(2'd3, 8'h04);
        wr(2'd3, 8'h02);
        wr(2'd2, 8'h18);
        wr(2'd0, 8'h07);
        wr(2'd3, 8'h01);
        idle(WR);
        rd(2'd2, v); chk("R8/R9 data kept", v, 8'h81);
        rd(2'd0, v); chk("R9 addr kept", v, 8'h01);
        mem_read(10'h001, v); chk("R9 stored byte", v, 8'h81);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule